// File: doc/BRIEF.md
# Audio Coprocessor I/O Register Decoder

This block decodes the memory bus of an 8-bit audio coprocessor that has a 16-bit address space. It sits between the core's bus (address, read and write strobes, write data) and a 64 KiB backing RAM. It steers every access to one of three places: the RAM, a sixteen-byte I/O window at 0x00F0–0x00FF, or a 64-byte boot ROM overlay at the top of memory. Read data is returned combinationally, in the cycle of the read. Writes take effect at the next rising clock edge.

The I/O window holds several things. There is a speed, timer and RAM-write control byte. There is a timer-enable and ROM-map control byte. An index/data pair reaches a 128-entry DSP register file held inside the block. There are two plain scratch latches, three write-only timer targets and three read-only timer count ports. The timers themselves and the DSP engine live outside the block; they only consume the control outputs.

Top module: `apu_io_decoder`

## Requirements
- R1: After reset the outputs read as follows: intSpeed=0, extSpeed=0, ramWrEnable=1, timerGlobalEn=1, timerEn=0 and every timer target 0. The boot ROM is mapped in, so a read of 0xFFC0 returns the ROM byte at offset 0.
- R2: A read of 0x00F0, 0x00F1, 0x00FA, 0x00FB or 0x00FC returns 0x00, whatever the RAM holds at that address.
- R3: While the ROM is mapped, a read in 0xFFC0–0xFFFF returns the ROM byte at offset k = address[5:0]. Its value is (29*k + 0x47) mod 256. While the ROM is unmapped, the same read returns the RAM byte.
- R4: A write raises ramWe, with ramAddr = busAddr and ramWrData = busWrData, when ramWrEnable holds the value it had before that write. This covers I/O window and ROM overlay addresses too. A write made while ramWrEnable=0 leaves the RAM unchanged.
- R5: A write to 0x00F0 made while dirPageFlag=0 loads intSpeed from bits 7:6, extSpeed from bits 5:4, the timers-on flag from bit 3, ramWrEnable from bit 1 and the timers-off flag from bit 0. While dirPageFlag=1 the write leaves all of these unchanged.
- R6: timerGlobalEn is high exactly when the timers-on flag is 1 and the timers-off flag is 0.
- R7: A write to 0x00F1 loads timerEn[2:0] from bits 2:0 and the ROM-map flag from bit 7.
- R8: 0x00F2 is a read/write DSP index. A read of 0x00F3 returns DSP entry index[6:0]. A write to 0x00F3 stores into DSP entry index[6:0] only when the index is below 128; otherwise the DSP file is unchanged.
- R9: A write to 0x00FA, 0x00FB or 0x00FC sets the target of timer 0, 1 or 2 (timerTarget bits 7:0, 15:8, 23:16). A read of 0x00FD, 0x00FE or 0x00FF returns timerCount bits 7:0, 15:8 or 23:16.
- R10: 0x00F8 and 0x00F9 are independent 8-bit latches that read back the last value written to them.
- R11: A read of any address not claimed by R2, R3, R8, R9 or R10 returns ramRdData. This includes 0x00F4–0x00F7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | 16 | Core bus address |
| busRd | input | 1 | Read strobe |
| busWr | input | 1 | Write strobe |
| busWrData | input | 8 | Write data from the core |
| busRdData | output | 8 | Read data to the core (0 when busRd is low) |
| dirPageFlag | input | 1 | Processor direct-page status flag; gates writes to the speed/control byte |
| ramAddr | output | 16 | Backing RAM address |
| ramWe | output | 1 | Backing RAM write enable |
| ramWrData | output | 8 | Backing RAM write data |
| ramRdData | input | 8 | Backing RAM read data (asynchronous) |
| timerCount | input | 24 | Counter outputs of timers 2,1,0 (byte 0 = timer 0) |
| intSpeed | output | 2 | Internal speed select |
| extSpeed | output | 2 | External speed select |
| ramWrEnable | output | 1 | RAM write-through enable flag |
| timerGlobalEn | output | 1 | Global timer run enable |
| timerEn | output | 3 | Per-timer enables |
| timerTarget | output | 24 | Timer targets, byte t for timer t |

## Verification
Two functions can land in the same cycle. A write to the control byte that clears bit 1 must still write through to RAM, because the write uses the enable it finds in place. A write into the ROM overlay reaches RAM while reads there still return ROM. The bench provokes the first case by writing 0x48 to 0x00F0. It then checks that its RAM model holds 0x48 and that a later plain write is dropped. It provokes the second by unmapping the ROM and reading back an overlay address, which must show RAM contents rather than the ROM formula.

// File: rtl/apu_io_pkg.sv
`timescale 1ns/1ps
package apu_io_pkg;
  localparam int ADDR_W = 16;
  localparam int DATA_W = 8;

  typedef enum logic [2:0] {
    SEL_RAM, SEL_ZERO, SEL_ROM, SEL_DSPIDX, SEL_DSPDAT, SEL_LATCH, SEL_TIMER
  } rdSel_e;

  typedef struct packed {
    logic       wrSpeed;
    logic       wrCtrl;
    logic       wrDspIdx;
    logic       wrDspDat;
    logic [1:0] wrLatch;
    logic [3:0] wrTgt;
    rdSel_e     rdSel;
    logic       latchIdx;
    logic [1:0] tmrIdx;
  } ioStrobe_t;

  function automatic logic [DATA_W-1:0] romByte(input int k);
    return DATA_W'((29 * k + 8'h47) % 256);
  endfunction
endpackage

// File: rtl/apu_io_ctrl.sv
`timescale 1ns/1ps
module apu_io_ctrl
  import apu_io_pkg::*;
#(
  parameter int NUM_TIMERS = 3,
  parameter int ROM_DEPTH  = 64
) (
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busRd,
  input  logic              busWr,
  input  logic              dirPageFlag,
  input  logic              romEn,
  output ioStrobe_t         strb
);
  localparam int ROM_IW = $clog2(ROM_DEPTH);
  localparam logic [ADDR_W-1:0] ROM_BASE = ADDR_W'((1 << ADDR_W) - ROM_DEPTH);

  logic       inWin;
  logic [3:0] lo;
  logic       inRom;
  logic       wrWin;

  assign inWin = (busAddr[ADDR_W-1:4] == 12'h00F);
  assign lo    = busAddr[3:0];
  assign inRom = romEn && (busAddr[ADDR_W-1:ROM_IW] == ROM_BASE[ADDR_W-1:ROM_IW]);
  assign wrWin = busWr && inWin;

  always_comb begin
    strb.wrSpeed  = wrWin && (lo == 4'h0) && !dirPageFlag;
    strb.wrCtrl   = wrWin && (lo == 4'h1);
    strb.wrDspIdx = wrWin && (lo == 4'h2);
    strb.wrDspDat = wrWin && (lo == 4'h3);
    strb.wrLatch  = {wrWin && (lo == 4'h9), wrWin && (lo == 4'h8)};
  end

  for (genvar t = 0; t < 4; t++) begin : g_tgt
    if (t < NUM_TIMERS) begin : g_on
      assign strb.wrTgt[t] = wrWin && (lo == 4'(10 + t));
    end else begin : g_off
      assign strb.wrTgt[t] = 1'b0;
    end
  end

  always_comb begin
    strb.rdSel    = SEL_RAM;
    strb.latchIdx = lo[0];
    strb.tmrIdx   = 2'(lo - 4'd13);
    if (!busRd) begin
      strb.rdSel = SEL_ZERO;
    end else if (inRom) begin
      strb.rdSel = SEL_ROM;
    end else if (inWin) begin
      unique case (lo)
        4'h0, 4'h1, 4'hA, 4'hB, 4'hC: strb.rdSel = SEL_ZERO;
        4'h2:                         strb.rdSel = SEL_DSPIDX;
        4'h3:                         strb.rdSel = SEL_DSPDAT;
        4'h8, 4'h9:                   strb.rdSel = SEL_LATCH;
        4'hD, 4'hE, 4'hF:             strb.rdSel = SEL_TIMER;
        default:                      strb.rdSel = SEL_RAM;
      endcase
    end
  end
endmodule

// File: rtl/apu_io_datapath.sv
`timescale 1ns/1ps
module apu_io_datapath
  import apu_io_pkg::*;
#(
  parameter int NUM_TIMERS = 3,
  parameter int DSP_DEPTH  = 128,
  parameter int ROM_DEPTH  = 64
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  ioStrobe_t                    strb,
  input  logic [ADDR_W-1:0]            busAddr,
  input  logic [DATA_W-1:0]            busWrData,
  input  logic [DATA_W-1:0]            ramRdData,
  input  logic [NUM_TIMERS*DATA_W-1:0] timerCount,
  output logic [DATA_W-1:0]            busRdData,
  output logic [1:0]                   intSpeed,
  output logic [1:0]                   extSpeed,
  output logic                         ramWrEnable,
  output logic                         timersOn,
  output logic                         timersOff,
  output logic [NUM_TIMERS-1:0]        timerEn,
  output logic                         romEn,
  output logic [NUM_TIMERS*DATA_W-1:0] timerTarget
);
  localparam int DSP_IW = $clog2(DSP_DEPTH);
  localparam int ROM_IW = $clog2(ROM_DEPTH);

  logic [DATA_W-1:0] dspIdx;
  logic [DATA_W-1:0] dspFile [DSP_DEPTH];
  logic [DATA_W-1:0] latchReg [2];
  logic [DSP_IW-1:0] dspSel;
  logic              dspOk;

  assign dspSel = dspIdx[DSP_IW-1:0];
  assign dspOk  = (int'(dspIdx) < DSP_DEPTH);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      intSpeed    <= '0;
      extSpeed    <= '0;
      ramWrEnable <= 1'b1;
      timersOn    <= 1'b1;
      timersOff   <= 1'b0;
      timerEn     <= '0;
      romEn       <= 1'b1;
      dspIdx      <= '0;
    end else begin
      if (strb.wrSpeed) begin
        intSpeed    <= busWrData[7:6];
        extSpeed    <= busWrData[5:4];
        timersOn    <= busWrData[3];
        ramWrEnable <= busWrData[1];
        timersOff   <= busWrData[0];
      end
      if (strb.wrCtrl) begin
        timerEn <= busWrData[NUM_TIMERS-1:0];
        romEn   <= busWrData[7];
      end
      if (strb.wrDspIdx) dspIdx <= busWrData;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < DSP_DEPTH; i++) dspFile[i] <= '0;
    end else if (strb.wrDspDat && dspOk) begin
      dspFile[dspSel] <= busWrData;
    end
  end

  for (genvar l = 0; l < 2; l++) begin : g_latch
    always_ff @(posedge clk) begin
      if (!rstN)              latchReg[l] <= '0;
      else if (strb.wrLatch[l]) latchReg[l] <= busWrData;
    end
  end

  for (genvar t = 0; t < NUM_TIMERS; t++) begin : g_target
    always_ff @(posedge clk) begin
      if (!rstN)              timerTarget[t*DATA_W +: DATA_W] <= '0;
      else if (strb.wrTgt[t]) timerTarget[t*DATA_W +: DATA_W] <= busWrData;
    end
  end

  always_comb begin
    unique case (strb.rdSel)
      SEL_ZERO:   busRdData = '0;
      SEL_ROM:    busRdData = romByte(int'(busAddr[ROM_IW-1:0]));
      SEL_DSPIDX: busRdData = dspIdx;
      SEL_DSPDAT: busRdData = dspFile[dspSel];
      SEL_LATCH:  busRdData = latchReg[strb.latchIdx];
      SEL_TIMER:  busRdData = (int'(strb.tmrIdx) < NUM_TIMERS)
                              ? timerCount[int'(strb.tmrIdx)*DATA_W +: DATA_W] : '0;
      default:    busRdData = ramRdData;
    endcase
  end
endmodule

// File: rtl/apu_io_decoder.sv
`timescale 1ns/1ps
module apu_io_decoder
  import apu_io_pkg::*;
#(
  parameter int NUM_TIMERS = 3,
  parameter int DSP_DEPTH  = 128,
  parameter int ROM_DEPTH  = 64
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic [ADDR_W-1:0]            busAddr,
  input  logic                         busRd,
  input  logic                         busWr,
  input  logic [DATA_W-1:0]            busWrData,
  output logic [DATA_W-1:0]            busRdData,
  input  logic                         dirPageFlag,
  output logic [ADDR_W-1:0]            ramAddr,
  output logic                         ramWe,
  output logic [DATA_W-1:0]            ramWrData,
  input  logic [DATA_W-1:0]            ramRdData,
  input  logic [NUM_TIMERS*DATA_W-1:0] timerCount,
  output logic [1:0]                   intSpeed,
  output logic [1:0]                   extSpeed,
  output logic                         ramWrEnable,
  output logic                         timerGlobalEn,
  output logic [NUM_TIMERS-1:0]        timerEn,
  output logic [NUM_TIMERS*DATA_W-1:0] timerTarget
);
  ioStrobe_t strb;
  logic      romEn;
  logic      timersOn;
  logic      timersOff;

  apu_io_ctrl #(.NUM_TIMERS(NUM_TIMERS), .ROM_DEPTH(ROM_DEPTH)) u_ctrl (
    .busAddr(busAddr), .busRd(busRd), .busWr(busWr),
    .dirPageFlag(dirPageFlag), .romEn(romEn), .strb(strb)
  );

  apu_io_datapath #(.NUM_TIMERS(NUM_TIMERS), .DSP_DEPTH(DSP_DEPTH), .ROM_DEPTH(ROM_DEPTH)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .busAddr(busAddr), .busWrData(busWrData),
    .ramRdData(ramRdData), .timerCount(timerCount), .busRdData(busRdData),
    .intSpeed(intSpeed), .extSpeed(extSpeed), .ramWrEnable(ramWrEnable),
    .timersOn(timersOn), .timersOff(timersOff), .timerEn(timerEn),
    .romEn(romEn), .timerTarget(timerTarget)
  );

  assign ramAddr       = busAddr;
  assign ramWrData     = busWrData;
  assign ramWe         = busWr && ramWrEnable;
  assign timerGlobalEn = timersOn && !timersOff;
endmodule

// File: rtl/apu_io_decoder_chk.sv
`timescale 1ns/1ps
module apu_io_decoder_chk #(
  parameter int NUM_TIMERS = 3
) (
  input logic                    clk,
  input logic                    rstN,
  input logic [15:0]             busAddr,
  input logic                    busRd,
  input logic                    busWr,
  input logic [7:0]              busWrData,
  input logic [7:0]              busRdData,
  input logic                    dirPageFlag,
  input logic                    ramWe,
  input logic [1:0]              intSpeed,
  input logic [1:0]              extSpeed,
  input logic                    ramWrEnable,
  input logic                    timerGlobalEn,
  input logic [NUM_TIMERS-1:0]   timerEn,
  input logic [NUM_TIMERS*8-1:0] timerTarget
);
  logic f0Wr;
  assign f0Wr = busWr && (busAddr == 16'h00F0);

  p_zero_reads_r2: assert property (@(posedge clk) disable iff (!rstN)
    busRd && (busAddr == 16'h00F0 || busAddr == 16'h00F1 || busAddr == 16'h00FA ||
              busAddr == 16'h00FB || busAddr == 16'h00FC) |-> busRdData == 8'h00);

  p_write_through_r4: assert property (@(posedge clk) disable iff (!rstN)
    busWr && ramWrEnable |-> ramWe);

  p_f0_blocked_r5: assert property (@(posedge clk) disable iff (!rstN)
    f0Wr && dirPageFlag |=> $stable(intSpeed) && $stable(extSpeed) && $stable(ramWrEnable));

  p_f0_load_r5: assert property (@(posedge clk) disable iff (!rstN)
    f0Wr && !dirPageFlag |=> intSpeed == $past(busWrData[7:6]) &&
                             extSpeed == $past(busWrData[5:4]) &&
                             ramWrEnable == $past(busWrData[1]));

  p_global_en_r6: assert property (@(posedge clk) disable iff (!rstN)
    f0Wr && !dirPageFlag |=> timerGlobalEn == ($past(busWrData[3]) && !$past(busWrData[0])));

  p_timer_en_r7: assert property (@(posedge clk) disable iff (!rstN)
    busWr && busAddr == 16'h00F1 |=> timerEn == $past(busWrData[NUM_TIMERS-1:0]));

  p_target0_r9: assert property (@(posedge clk) disable iff (!rstN)
    busWr && busAddr == 16'h00FA |=> timerTarget[7:0] == $past(busWrData));
endmodule

bind apu_io_decoder apu_io_decoder_chk #(.NUM_TIMERS(NUM_TIMERS)) u_chk (
  .clk(clk), .rstN(rstN), .busAddr(busAddr), .busRd(busRd), .busWr(busWr),
  .busWrData(busWrData), .busRdData(busRdData), .dirPageFlag(dirPageFlag),
  .ramWe(ramWe), .intSpeed(intSpeed), .extSpeed(extSpeed), .ramWrEnable(ramWrEnable),
  .timerGlobalEn(timerGlobalEn), .timerEn(timerEn), .timerTarget(timerTarget)
);

// File: tb/test_apu_io_decoder.sv
`timescale 1ns/1ps
module test_apu_io_decoder;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] busAddr = '0;
  logic        busRd = 1'b0;
  logic        busWr = 1'b0;
  logic [7:0]  busWrData = '0;
  logic [7:0]  busRdData;
  logic        dirPageFlag = 1'b0;
  logic [15:0] ramAddr;
  logic        ramWe;
  logic [7:0]  ramWrData;
  logic [7:0]  ramRdData;
  logic [23:0] timerCount = '0;
  logic [1:0]  intSpeed, extSpeed;
  logic        ramWrEnable, timerGlobalEn;
  logic [2:0]  timerEn;
  logic [23:0] timerTarget;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  logic [7:0] mem [4096];

  always #2.5 clk = ~clk;

  apu_io_decoder i_apu_io_decoder (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busRd(busRd), .busWr(busWr),
    .busWrData(busWrData), .busRdData(busRdData), .dirPageFlag(dirPageFlag),
    .ramAddr(ramAddr), .ramWe(ramWe), .ramWrData(ramWrData), .ramRdData(ramRdData),
    .timerCount(timerCount), .intSpeed(intSpeed), .extSpeed(extSpeed),
    .ramWrEnable(ramWrEnable), .timerGlobalEn(timerGlobalEn), .timerEn(timerEn),
    .timerTarget(timerTarget)
  );

  assign ramRdData = mem[ramAddr[11:0]];
  always @(posedge clk) if (ramWe) mem[ramAddr[11:0]] <= ramWrData;

  function automatic logic [7:0] romExp(input int k);
    return 8'((29 * k + 71) % 256);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic busWrite(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    busAddr = a; busWrData = d; busWr = 1'b1;
    @(negedge clk);
    busWr = 1'b0;
  endtask

  task automatic busRead(input logic [15:0] a, output logic [7:0] d);
    @(negedge clk);
    busAddr = a; busRd = 1'b1;
    #1 d = busRdData;
    @(negedge clk);
    busRd = 1'b0;
  endtask

  typedef struct packed {
    logic        wr;
    logic [15:0] addr;
    logic [7:0]  data;
    logic [7:0]  exp;
    logic [3:0]  req;
  } vec_t;

  localparam vec_t VEC [13] = '{
    '{1'b1, 16'h00F2, 8'h05, 8'h00, 4'd8},   // R8 index
    '{1'b0, 16'h00F2, 8'h00, 8'h05, 4'd8},   // R8 index readback
    '{1'b1, 16'h00F3, 8'hA7, 8'h00, 4'd8},   // R8 data write
    '{1'b0, 16'h00F3, 8'h00, 8'hA7, 4'd8},   // R8 data readback
    '{1'b1, 16'h00F8, 8'h3C, 8'h00, 4'd10},  // R10 latch 0
    '{1'b0, 16'h00F8, 8'h00, 8'h3C, 4'd10},  // R10
    '{1'b1, 16'h00F9, 8'hC4, 8'h00, 4'd10},  // R10 latch 1
    '{1'b0, 16'h00F9, 8'h00, 8'hC4, 4'd10},  // R10
    '{1'b0, 16'h00F0, 8'h00, 8'h00, 4'd2},   // R2 zero read
    '{1'b0, 16'h00FA, 8'h00, 8'h00, 4'd2},   // R2 zero read
    '{1'b0, 16'hFFC5, 8'h00, 8'hD8, 4'd3},   // R3 ROM offset 5
    '{1'b1, 16'h0123, 8'h5E, 8'h00, 4'd4},   // R4 plain write
    '{1'b0, 16'h0123, 8'h00, 8'h5E, 4'd11}   // R11 plain read
  };

  initial begin
    #1_000_000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [7:0] rd;
    for (int i = 0; i < 4096; i++) mem[i] = 8'(i) ^ 8'hC3;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 intSpeed", 32'(intSpeed), 0);
    check("R1 extSpeed", 32'(extSpeed), 0);
    check("R1 ramWrEnable", 32'(ramWrEnable), 1);
    check("R1 timerGlobalEn", 32'(timerGlobalEn), 1);
    check("R1 timerEn", 32'(timerEn), 0);
    check("R1 timerTarget", 32'(timerTarget), 0);
    busRead(16'hFFC0, rd);
    check("R1 ROM mapped", 32'(rd), 32'(romExp(0)));

    for (int v = 0; v < 13; v++) begin
      if (VEC[v].wr) busWrite(VEC[v].addr, VEC[v].data);
      else begin
        busRead(VEC[v].addr, rd);
        check($sformatf("R%0d vector %0d", VEC[v].req, v), 32'(rd), 32'(VEC[v].exp));
      end
    end

    // R3 top of ROM
    busRead(16'hFFFF, rd);
    check("R3 ROM offset 63", 32'(rd), 32'(romExp(63)));

    // R9 timer targets and counts
    busWrite(16'h00FA, 8'h11);
    busWrite(16'h00FB, 8'h22);
    busWrite(16'h00FC, 8'h33);
    check("R9 targets", 32'(timerTarget), 32'h332211);
    busRead(16'h00FB, rd);
    check("R2 target not readable", 32'(rd), 0);
    timerCount = 24'h9A7B5C;
    busRead(16'h00FD, rd); check("R9 count0", 32'(rd), 32'h5C);
    busRead(16'h00FE, rd); check("R9 count1", 32'(rd), 32'h7B);
    busRead(16'h00FF, rd); check("R9 count2", 32'(rd), 32'h9A);

    // R7 control byte
    busWrite(16'h00F1, 8'h85);
    check("R7 timerEn", 32'(timerEn), 32'h5);
    busRead(16'hFFC5, rd); check("R7 ROM still mapped", 32'(rd), 32'(romExp(5)));
    busWrite(16'h00F1, 8'h03);
    check("R7 timerEn 2", 32'(timerEn), 32'h3);
    busRead(16'h00F1, rd); check("R2 F1 reads zero", 32'(rd), 0);
    check("R4 F1 written to RAM", 32'(mem[12'h0F1]), 32'h03);
    busWrite(16'hFFC9, 8'hE1);
    busRead(16'hFFC9, rd); check("R3 unmapped reads RAM", 32'(rd), 32'hE1);

    // R5 blocked by direct-page flag
    dirPageFlag = 1'b1;
    busWrite(16'h00F0, 8'hC1);
    check("R5 blocked intSpeed", 32'(intSpeed), 0);
    check("R5 blocked ramWrEnable", 32'(ramWrEnable), 1);
    check("R6 blocked globalEn", 32'(timerGlobalEn), 1);
    dirPageFlag = 1'b0;

    // R5 / R6 field decode
    busWrite(16'h00F0, 8'h9B);
    check("R5 intSpeed", 32'(intSpeed), 2);
    check("R5 extSpeed", 32'(extSpeed), 1);
    check("R6 on and off", 32'(timerGlobalEn), 0);
    busWrite(16'h00F0, 8'h48);
    check("R5 intSpeed 2", 32'(intSpeed), 1);
    check("R5 ramWrEnable cleared", 32'(ramWrEnable), 0);
    check("R6 on only", 32'(timerGlobalEn), 1);
    check("R4 clearing write reached RAM", 32'(mem[12'h0F0]), 32'h48);

    // R4 writes dropped while disabled
    busWrite(16'h0200, 8'h77);
    busRead(16'h0200, rd); check("R4 dropped write", 32'(rd), 32'hC3);
    busRead(16'h00F5, rd); check("R11 F5 reads RAM", 32'(rd), 32'h36);

    // R8 out-of-range index
    busWrite(16'h00F2, 8'h85);
    busRead(16'h00F2, rd); check("R8 index high", 32'(rd), 32'h85);
    busRead(16'h00F3, rd); check("R8 read uses low bits", 32'(rd), 32'hA7);
    busWrite(16'h00F3, 8'h11);
    busWrite(16'h00F2, 8'h05);
    busRead(16'h00F3, rd); check("R8 blocked write", 32'(rd), 32'hA7);

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule